// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block takes two double-precision values and orders them. The result is one of four: greater, less, equal or unordered. It turns that result into three status bits, named zero, parity and carry. Three more status bits, overflow, sign and auxiliary carry, are always reported as clear. The block sits in an execution pipeline behind operand fetch. A strobe starts each compare, and the registered flags appear one cycle later together with a result strobe.

Two policies cover NaN inputs, and a mode pin picks between them:

- **Signaling compare:** any NaN raises the invalid-operation event.
- **Quiet compare:** only a signaling NaN raises the invalid-operation event.

A mask pin decides what a raised event does:

- **Unmasked:** the event blocks the flag write, so the earlier flags stay in place.
- **Masked:** the flags are written as usual, and a sticky invalid bit is set. The sticky bit stays set until reset.

Top module: `fcmp_flag_unit`

## Requirements
- R1: When either operand is a NaN and the flags are written, {zf,pf,cf} becomes 3'b111. A NaN has an exponent field of all ones and a nonzero fraction.
- R2: For ordered operands the written {zf,pf,cf} is 3'b000 when a is greater than b, 3'b001 when a is less than b, and 3'b100 when they are equal.
- R3: Positive zero and negative zero compare as equal.
- R4: Non-NaN values order by sign and magnitude:
  - Among negatives, a larger magnitude is the smaller value.
  - Infinities are the largest magnitudes.
  - Denormals order above zero.
- R5: The of, sf and af outputs read 0 on every result.
- R6: With quiet_mode=0 (signaling compare), inv_raised is 1 in the result cycle when either operand is any NaN.
- R7: With quiet_mode=1, inv_raised is 1 only when an operand is a signaling NaN, meaning fraction bit 51 is 0. A quiet NaN, with bit 51 equal to 1, gives inv_raised=0.
- R8: When inv_raised is 1 and inv_mask=0, {zf,pf,cf} keep their previous values, and inv_sticky is not set.
- R9: When the invalid event is raised and inv_mask=1, the flags are written and inv_sticky becomes 1. inv_sticky then stays 1 until reset.
- R10: out_valid is 1 exactly one cycle after in_valid. Without in_valid, out_valid and inv_raised are 0 and the flags hold.
- R11: After reset, out_valid, inv_raised, inv_sticky and all six flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Starts a compare of op_a and op_b |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| quiet_mode | input | 1 | 1 = quiet compare, 0 = signaling compare |
| inv_mask | input | 1 | 1 = invalid event is masked |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| zf | output | 1 | Zero flag |
| pf | output | 1 | Parity flag |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag, always 0 |
| sf | output | 1 | Sign flag, always 0 |
| af | output | 1 | Auxiliary carry flag, always 0 |
| inv_raised | output | 1 | Invalid event for this result |
| inv_sticky | output | 1 | Sticky masked-invalid status |

## Verification
Each fault shows at the ports in the result cycle right after its strobe:

- A wrong classification of a NaN, or of its quiet bit, shows as a missing or extra inv_raised pulse. It may also show as a wrong three-bit flag code.
- A wrong ordering decision, such as a sign reversal, zero handling or an infinity, shows as the wrong flag code.
- A broken update gate hides until the next result. There it appears as flags that changed under an unmasked event, or that stayed the same under a masked one.
- A broken sticky bit shows in every later cycle.

The vectors therefore put each class of value on both sides of the compare, and then read the flags once more after the event cycles.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef enum logic [1:0] {
    CMP_GT = 2'd0,
    CMP_LT = 2'd1,
    CMP_EQ = 2'd2,
    CMP_UN = 2'd3
  } cmp_res_e;

  typedef struct packed {
    logic is_nan;
    logic is_snan;
  } op_class_t;

  // Three-bit {zero, parity, carry} code for a compare outcome
  function automatic logic [2:0] flag_code(cmp_res_e r);
    case (r)
      CMP_GT:  flag_code = 3'b000;
      CMP_LT:  flag_code = 3'b001;
      CMP_EQ:  flag_code = 3'b100;
      default: flag_code = 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] op,
  output op_class_t             cls
);
  localparam int W = 1 + EXP_W + FRAC_W;

  function automatic op_class_t classify(logic [W-1:0] v);
    op_class_t c;
    logic exp_ones;
    logic frac_nz;
    exp_ones  = &v[W-2:FRAC_W];
    frac_nz   = |v[FRAC_W-1:0];
    c.is_nan  = exp_ones && frac_nz;
    c.is_snan = exp_ones && frac_nz && !v[FRAC_W-1];
    return c;
  endfunction

  assign cls = classify(op);

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  output cmp_res_e              ord,
  output logic                  a_gt,
  output logic                  a_lt,
  output logic                  a_eq
);
  localparam int W = 1 + EXP_W + FRAC_W;

  // Sign-magnitude ordering of two non-NaN values
  function automatic cmp_res_e order_sm(logic [W-1:0] x, logic [W-1:0] y);
    logic [W-2:0] mx;
    logic [W-2:0] my;
    mx = x[W-2:0];
    my = y[W-2:0];
    if ((mx == '0) && (my == '0))  return CMP_EQ;
    if (x == y)                    return CMP_EQ;
    if (x[W-1] != y[W-1])          return x[W-1] ? CMP_LT : CMP_GT;
    if (x[W-1])                    return (mx < my) ? CMP_GT : CMP_LT;
    return (mx > my) ? CMP_GT : CMP_LT;
  endfunction

  assign ord  = order_sm(a, b);
  assign a_gt = (ord == CMP_GT);
  assign a_lt = (ord == CMP_LT);
  assign a_eq = (ord == CMP_EQ);

endmodule

// File: rtl/fcmp_flag_reg.sv
module fcmp_flag_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       inv_ev,
  input  logic       inv_mask,
  input  logic [2:0] code,
  output logic       valid_q,
  output logic       inv_q,
  output logic [2:0] zpc_q,
  output logic       sticky_q
);
  logic wr_en;
  logic set_sticky;

  assign wr_en      = in_valid && !(inv_ev && !inv_mask);
  assign set_sticky = in_valid && inv_ev && inv_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      inv_q    <= 1'b0;
      zpc_q    <= 3'b000;
      sticky_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      inv_q   <= in_valid && inv_ev;
      if (wr_en)      zpc_q    <= code;
      if (set_sticky) sticky_q <= 1'b1;
    end
  end

  // R9: sticky status never clears outside reset
  p_sticky_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_q |=> sticky_q);

  // R10: idle cycles leave the flags alone
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(zpc_q));

endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         quiet_mode,
  input  logic         inv_mask,
  output logic         out_valid,
  output logic         zf,
  output logic         pf,
  output logic         cf,
  output logic         of,
  output logic         sf,
  output logic         af,
  output logic         inv_raised,
  output logic         inv_sticky
);
  logic [W-1:0] ops [2];
  op_class_t    cls [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op  (ops[i]),
      .cls (cls[i])
    );
  end

  // Named internal events for the checks
  logic     any_nan;
  logic     any_snan;
  logic     inv_hit;
  cmp_res_e ord;
  cmp_res_e res;
  logic     a_gt, a_lt, a_eq;
  logic [2:0] code;
  logic [2:0] zpc_q;

  assign any_nan  = cls[0].is_nan  || cls[1].is_nan;
  assign any_snan = cls[0].is_snan || cls[1].is_snan;
  assign inv_hit  = quiet_mode ? any_snan : any_nan;

  fcmp_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_ord (
    .a    (op_a),
    .b    (op_b),
    .ord  (ord),
    .a_gt (a_gt),
    .a_lt (a_lt),
    .a_eq (a_eq)
  );

  assign res  = any_nan ? CMP_UN : ord;
  assign code = flag_code(res);

  fcmp_flag_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .inv_ev   (inv_hit),
    .inv_mask (inv_mask),
    .code     (code),
    .valid_q  (out_valid),
    .inv_q    (inv_raised),
    .zpc_q    (zpc_q),
    .sticky_q (inv_sticky)
  );

  assign {zf, pf, cf} = zpc_q;
  assign of = 1'b0;
  assign sf = 1'b0;
  assign af = 1'b0;

  // R2: ordered inputs give exactly one ordering outcome
  p_one_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !any_nan) |-> ($countones({a_gt, a_lt, a_eq}) == 1));

  // R1: a written NaN result reads as all ones
  p_unord_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && any_nan && !(inv_hit && !inv_mask)) |=> ({zf, pf, cf} == 3'b111));

  // R6: signaling mode flags every NaN
  p_sig_nan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !quiet_mode && any_nan) |=> inv_raised);

  // R7: quiet mode ignores quiet NaNs
  p_quiet_qnan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && quiet_mode && !any_snan) |=> !inv_raised);

  // R8: unmasked invalid keeps the flags
  p_hold_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && inv_hit && !inv_mask) |=> $stable({zf, pf, cf}));

  // R10: result strobe follows the request strobe by one cycle
  p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !inv_raised));

  // R5: cleared flags stay cleared
  p_zero_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ({of, sf, af} == 3'b000));

endmodule

// File: tb/fcmp_flag_unit_bench.sv
module fcmp_flag_unit_bench;

  localparam logic [63:0] PZ    = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZ    = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONE   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] TWO   = 64'h4000_0000_0000_0000;
  localparam logic [63:0] MONE  = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] MTWO  = 64'hC000_0000_0000_0000;
  localparam logic [63:0] PINF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF  = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] MAXN  = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] DEN   = 64'h0000_0000_0000_0001;
  localparam logic [63:0] QNAN  = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] NQNAN = 64'hFFF8_0000_0000_0001;
  localparam logic [63:0] SNAN  = 64'h7FF0_0000_0000_0001;

  // {a, b, quiet, mask, expected zpc, expected inv}
  localparam int NV = 16;
  localparam logic [133:0] VEC [NV] = '{
    {ONE,  TWO,   1'b0, 1'b1, 3'b001, 1'b0},  // R2 less
    {TWO,  ONE,   1'b0, 1'b1, 3'b000, 1'b0},  // R2 greater
    {ONE,  ONE,   1'b0, 1'b1, 3'b100, 1'b0},  // R2 equal
    {PZ,   NZ,    1'b0, 1'b1, 3'b100, 1'b0},  // R3
    {MONE, MTWO,  1'b0, 1'b1, 3'b000, 1'b0},  // R4 negatives
    {MTWO, MONE,  1'b0, 1'b1, 3'b001, 1'b0},  // R4
    {PINF, MAXN,  1'b0, 1'b1, 3'b000, 1'b0},  // R4 infinity
    {NINF, MTWO,  1'b0, 1'b1, 3'b001, 1'b0},  // R4
    {DEN,  PZ,    1'b0, 1'b1, 3'b000, 1'b0},  // R4 denormal
    {NZ,   DEN,   1'b0, 1'b1, 3'b001, 1'b0},  // R3/R4
    {MONE, ONE,   1'b0, 1'b1, 3'b001, 1'b0},  // R4 signs
    {QNAN, ONE,   1'b0, 1'b1, 3'b111, 1'b1},  // R1 R6
    {ONE,  QNAN,  1'b1, 1'b1, 3'b111, 1'b0},  // R1 R7
    {SNAN, ONE,   1'b1, 1'b1, 3'b111, 1'b1},  // R7
    {ONE,  NQNAN, 1'b0, 1'b1, 3'b111, 1'b1},  // R6
    {PINF, PINF,  1'b0, 1'b1, 3'b100, 1'b0}   // R2
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic        quiet_mode = 1'b0;
  logic        inv_mask = 1'b1;
  logic        out_valid, zf, pf, cf, of, sf, af, inv_raised, inv_sticky;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fcmp_flag_unit u_fcmp_flag_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_b(op_b), .quiet_mode(quiet_mode), .inv_mask(inv_mask),
    .out_valid(out_valid), .zf(zf), .pf(pf), .cf(cf),
    .of(of), .sf(sf), .af(af),
    .inv_raised(inv_raised), .inv_sticky(inv_sticky)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One strobe; outputs sampled at the negedge after the capturing edge
  task automatic run(logic [63:0] a, logic [63:0] b, logic q, logic m);
    @(negedge clk);
    op_a = a; op_b = b; quiet_mode = q; inv_mask = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic chk_res(string req, logic [2:0] zpc, logic inv);
    check({req, " flags"}, {29'd0, zf, pf, cf}, {29'd0, zpc});
    check({req, " inv"}, {31'd0, inv_raised}, {31'd0, inv});
    check("R10 out_valid", {31'd0, out_valid}, 32'd1);
    check("R5 of/sf/af", {29'd0, of, sf, af}, 32'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11 reset state
    check("R11 reset outputs",
          {23'd0, out_valid, zf, pf, cf, of, sf, af, inv_raised, inv_sticky}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][133:70], VEC[i][69:6], VEC[i][5], VEC[i][4]);
      chk_res($sformatf("R1/R2/R3/R4/R6/R7 vec%0d", i), VEC[i][3:1], VEC[i][0]);
    end
    check("R9 sticky after masked events", {31'd0, inv_sticky}, 32'd1);

    // R8: unmasked event holds flags and leaves sticky clear
    do_reset();
    run(TWO, ONE, 1'b0, 1'b0);
    chk_res("R2 greater", 3'b000, 1'b0);
    run(QNAN, ONE, 1'b0, 1'b0);
    chk_res("R8 hold after signaling", 3'b000, 1'b1);
    check("R8 sticky clear", {31'd0, inv_sticky}, 32'd0);
    run(ONE, QNAN, 1'b1, 1'b0);
    chk_res("R7 quiet qnan writes", 3'b111, 1'b0);
    run(ONE, ONE, 1'b1, 1'b0);
    chk_res("R2 equal", 3'b100, 1'b0);
    run(SNAN, ONE, 1'b1, 1'b0);
    chk_res("R8 hold after snan", 3'b100, 1'b1);
    check("R8 sticky still clear", {31'd0, inv_sticky}, 32'd0);

    // R10: idle cycles hold flags, no strobe
    @(negedge clk);
    op_a = MONE; op_b = ONE; quiet_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 idle out_valid", {31'd0, out_valid}, 32'd0);
    check("R10 idle inv", {31'd0, inv_raised}, 32'd0);
    check("R10 idle flags", {29'd0, zf, pf, cf}, 32'b100);

    // R9: masked event writes flags and sets sticky, which persists
    run(SNAN, SNAN, 1'b1, 1'b1);
    chk_res("R9 masked write", 3'b111, 1'b1);
    check("R9 sticky set", {31'd0, inv_sticky}, 32'd1);
    run(MTWO, MONE, 1'b0, 1'b1);
    chk_res("R4 negatives", 3'b001, 1'b0);
    check("R9 sticky kept", {31'd0, inv_sticky}, 32'd1);
    repeat (2) @(negedge clk);
    check("R9 sticky idle", {31'd0, inv_sticky}, 32'd1);

    do_reset();
    check("R11 sticky cleared by reset", {31'd0, inv_sticky}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule